// File: doc/BRIEF.md
# Processor Run-State Controller

This block is the top-level mode keeper of a small processor. After reset it sits in a loading mode. In that mode it turns an incoming stream of bytes into sequential writes. The first bytes fill the instruction region. Once that region is full, the following bytes fill a separate read-only region. A byte carrying the last flag ends loading and starts execution.

While running, the core presents each retired instruction's 8-bit opcode. With it come the program counter it was fetched from and two execution-fault flags. The controller decodes the opcode as valid, halt or invalid, using the upper nibble as a group and the lower nibble as a modifier within that group. It then either keeps running, stops cleanly, or records a failure.

Both terminal modes are absorbing: nothing moves the controller out of them except reset. The core gates its own progress with the step enable output. Software or a debugger reads the outcome from the status code.

Top module: `run_state_ctrl`

## Requirements
- R1: While `rst_n` is low and directly after reset, `status` is 0 (loading), `step_en` is 0, and the next accepted load byte is written to address 0.
- R2: In loading mode, a cycle with `ld_valid` high raises `ld_wr_en` in that same cycle, with `ld_wr_data` equal to `ld_byte`. The k-th accepted byte (k counted from 0, k < IMEM_DEPTH) goes to address k.
- R3: Byte k with IMEM_DEPTH <= k < IMEM_DEPTH+RO_DEPTH goes to address RO_BASE + (k - IMEM_DEPTH). Bytes beyond IMEM_DEPTH+RO_DEPTH are not written: `ld_wr_en` stays 0.
- R4: A loading-mode cycle with `ld_valid` and `ld_last` both high makes `status` 2 (running) and `step_en` 1 from the next cycle. This holds even when that byte falls beyond the capacity.
- R5: An opcode is valid when its modifier (bits 3:0) is below the width of its group (bits 7:4). The group widths are: group 1 → 1, 2 → 7, 3 → 4, 4 → 2, 5 → 13, 6 → 5, 7 → 2, 8 → 1. All other groups have width 0. Opcode 0x10 is the no-operation and 0x80 is the halt.
- R6: In running mode, a retired valid opcode other than 0x80, with no fault present, leaves `status` at 2.
- R7: In running mode, a retired 0x80 with no fault present makes `status` 3 (halted) and `step_en` 0 from the next cycle.
- R8: In running mode, a retired invalid opcode makes `status` 4 (failed) and `step_en` 0 from the next cycle.
- R9: In running mode, a retirement whose `pc` is at or above IMEM_DEPTH leads to `status` 4 the next cycle. A `pc` of IMEM_DEPTH-1 is in range.
- R10: In running mode, a retirement with `flt_reg` or `flt_mem` high leads to `status` 4 the next cycle.
- R11: When a halt opcode retires together with any fault, the failure wins and `status` becomes 4, not 3.
- R12: Once `status` is 3 or 4 it keeps that value until reset, whatever arrives on any input. In that state `step_en` and `ld_wr_en` stay 0.
- R13: `op_valid` in loading mode has no effect on the mode. `ld_valid` outside loading mode produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | A load byte is present this cycle |
| ld_byte | input | 8 | Load byte value |
| ld_last | input | 1 | This byte ends the load |
| ld_wr_en | output | 1 | Write strobe toward program memory |
| ld_wr_addr | output | ADDR_W | Write address |
| ld_wr_data | output | 8 | Write data |
| op_valid | input | 1 | An instruction retires this cycle |
| opcode | input | 8 | Opcode of the retiring instruction |
| pc | input | ADDR_W | Program counter of the retiring instruction |
| flt_reg | input | 1 | Register-range fault during execution |
| flt_mem | input | 1 | Memory-access fault during execution |
| status | output | 3 | Mode code: 0 loading, 2 running, 3 halted, 4 failed |
| step_en | output | 1 | High only in running mode |

## Verification
The write port is combinational from the load inputs. The bench therefore checks `ld_wr_en`, `ld_wr_addr` and `ld_wr_data` a short delay after driving a byte, before the next rising edge. Mode changes pass through one register. The bench drives a retirement or a last byte on a falling edge and reads `status` and `step_en` at the following falling edge, exactly one clock later. All 256 opcodes are swept, each from a freshly loaded running state. The fault combinations are swept together with the program-counter boundary.

// File: rtl/run_state_pkg.sv
// Shared definitions for the run-state controller: mode encoding, the
// status codes seen at the port and the opcode group widths.
package run_state_pkg;

    typedef enum logic [1:0] {
        M_LOAD = 2'd0,
        M_RUN  = 2'd1,
        M_HALT = 2'd2,
        M_FAIL = 2'd3
    } mode_t;

    localparam logic [2:0] ST_LOAD = 3'd0;
    localparam logic [2:0] ST_RUN  = 3'd2;
    localparam logic [2:0] ST_HALT = 3'd3;
    localparam logic [2:0] ST_FAIL = 3'd4;

    localparam logic [7:0] OP_NOP  = 8'h10;
    localparam logic [7:0] OP_HALT = 8'h80;

    // Number of populated modifiers in each opcode group (0 = group unused).
    function automatic logic [4:0] group_span(input logic [3:0] grp);
        case (grp)
            4'd1:    group_span = 5'd1;
            4'd2:    group_span = 5'd7;
            4'd3:    group_span = 5'd4;
            4'd4:    group_span = 5'd2;
            4'd5:    group_span = 5'd13;
            4'd6:    group_span = 5'd5;
            4'd7:    group_span = 5'd2;
            4'd8:    group_span = 5'd1;
            default: group_span = 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/opcode_classifier.sv
// Opcode classifier.
// Decodes an 8-bit opcode into valid / halt. The upper nibble picks a
// group and the lower nibble must fall below that group's width.
// Assumes: purely combinational, evaluated every cycle.
module opcode_classifier
    import run_state_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       is_valid,
    output logic       is_halt
);

    logic [4:0] span;

    // Look up the group width and compare the modifier against it.
    always_comb begin
        span     = group_span(opcode[7:4]);
        is_valid = ({1'b0, opcode[3:0]} < span);
        is_halt  = (opcode == OP_HALT);
    end

endmodule

// File: rtl/image_loader.sv
// Sequential image loader.
// Writes accepted bytes first to the instruction region starting at
// address 0, then to the read-only region starting at RO_BASE. Bytes
// beyond the combined capacity are dropped.
// Assumes: 'active' is high only in loading mode; the regions do not
// overlap and fit in the ADDR_W address space.
module image_loader #(
    parameter int IMEM_DEPTH = 16,
    parameter int RO_DEPTH   = 8,
    parameter int RO_BASE    = 32,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              ld_valid,
    input  logic [7:0]        ld_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    localparam int CAP   = IMEM_DEPTH + RO_DEPTH;
    localparam int CNT_W = $clog2(CAP + 1);
    localparam logic [CNT_W-1:0] IMEM_LIM = CNT_W'(IMEM_DEPTH);
    localparam logic [CNT_W-1:0] CAP_LIM  = CNT_W'(CAP);

    logic [CNT_W-1:0] cnt;
    logic             room;

    // Decide whether this byte is written and where it lands.
    always_comb begin
        room    = (cnt < CAP_LIM);
        wr_en   = active && ld_valid && room;
        wr_data = ld_byte;
        if (cnt < IMEM_LIM)
            wr_addr = ADDR_W'(cnt);
        else
            wr_addr = ADDR_W'(RO_BASE) + ADDR_W'(cnt - IMEM_LIM);
    end

    // Count written bytes; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_en)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/mode_fsm.sv
// Run-mode state machine.
// Loading -> running on the last load byte. From running, a retirement
// goes to failed on any fault or invalid opcode, otherwise to halted on
// a halt opcode, otherwise stays running. Halted and failed are final.
// Assumes: 'retire' and fault flags describe the same instruction.
module mode_fsm
    import run_state_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld_valid,
    input  logic  ld_last,
    input  logic  retire,
    input  logic  is_valid,
    input  logic  is_halt,
    input  logic  pc_bad,
    input  logic  exec_fault,
    output mode_t mode
);

    mode_t mode_nx;
    logic  failing;

    // Next-mode selection, failure taking priority over halt.
    always_comb begin
        failing = !is_valid || pc_bad || exec_fault;
        mode_nx = mode;
        case (mode)
            M_LOAD: if (ld_valid && ld_last) mode_nx = M_RUN;
            M_RUN: begin
                if (retire) begin
                    if (failing)      mode_nx = M_FAIL;
                    else if (is_halt) mode_nx = M_HALT;
                end
            end
            default: mode_nx = mode;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= M_LOAD;
        else
            mode <= mode_nx;
    end

endmodule

// File: rtl/run_state_ctrl.sv
// Processor run-state controller (top).
// Ties the loader, the opcode classifier and the mode machine together
// and maps the mode to the status code and step enable.
// Assumes: RO_BASE >= IMEM_DEPTH and RO_BASE + RO_DEPTH <= 2**ADDR_W.
module run_state_ctrl
    import run_state_pkg::*;
#(
    parameter int IMEM_DEPTH = 16,
    parameter int RO_DEPTH   = 8,
    parameter int RO_BASE    = 32,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [7:0]        ld_byte,
    input  logic              ld_last,
    output logic              ld_wr_en,
    output logic [ADDR_W-1:0] ld_wr_addr,
    output logic [7:0]        ld_wr_data,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] pc,
    input  logic              flt_reg,
    input  logic              flt_mem,
    output logic [2:0]        status,
    output logic              step_en
);

    localparam logic [ADDR_W:0] PC_LIM = (ADDR_W+1)'(IMEM_DEPTH);

    mode_t mode;
    logic  is_valid;
    logic  is_halt;
    logic  pc_bad;
    logic  exec_fault;
    logic  loading;

    // Fault summary for the retiring instruction.
    always_comb begin
        pc_bad     = ({1'b0, pc} >= PC_LIM);
        exec_fault = flt_reg || flt_mem;
        loading    = (mode == M_LOAD);
    end

    image_loader #(
        .IMEM_DEPTH (IMEM_DEPTH),
        .RO_DEPTH   (RO_DEPTH),
        .RO_BASE    (RO_BASE),
        .ADDR_W     (ADDR_W)
    ) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (loading),
        .ld_valid (ld_valid),
        .ld_byte  (ld_byte),
        .wr_en    (ld_wr_en),
        .wr_addr  (ld_wr_addr),
        .wr_data  (ld_wr_data)
    );

    opcode_classifier u_cls (
        .opcode   (opcode),
        .is_valid (is_valid),
        .is_halt  (is_halt)
    );

    mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .ld_last    (ld_last),
        .retire     (op_valid),
        .is_valid   (is_valid),
        .is_halt    (is_halt),
        .pc_bad     (pc_bad),
        .exec_fault (exec_fault),
        .mode       (mode)
    );

    // Map the mode onto the externally visible status code.
    always_comb begin
        case (mode)
            M_LOAD:  status = ST_LOAD;
            M_RUN:   status = ST_RUN;
            M_HALT:  status = ST_HALT;
            default: status = ST_FAIL;
        endcase
        step_en = (mode == M_RUN);
    end

endmodule

// File: rtl/run_state_chk.sv
// Checker for the run-state controller, observing ports only.
module run_state_chk #(
    parameter int IMEM_DEPTH = 16,
    parameter int ADDR_W     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic              ld_last,
    input logic              ld_wr_en,
    input logic              op_valid,
    input logic [7:0]        opcode,
    input logic [ADDR_W-1:0] pc,
    input logic              flt_reg,
    input logic              flt_mem,
    input logic [2:0]        status,
    input logic              step_en
);

    logic pc_out;
    assign pc_out = ({1'b0, pc} >= (ADDR_W+1)'(IMEM_DEPTH));

    a_r4_last_starts_run: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && ld_valid && ld_last) |=> (status == 3'd2));

    a_r12_halt_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd3) |=> (status == 3'd3));

    a_r12_fail_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd4) |=> (status == 3'd4));

    a_r13_write_only_loading: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr_en |-> (status == 3'd0));

    a_r10_exec_fault_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_valid && (flt_reg || flt_mem)) |=> (status == 3'd4));

    a_r9_pc_range_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_valid && pc_out) |=> (status == 3'd4));

    a_r7_clean_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_valid && opcode == 8'h80 && !flt_reg && !flt_mem && !pc_out)
        |=> (status == 3'd3));

endmodule

bind run_state_ctrl run_state_chk #(
    .IMEM_DEPTH (IMEM_DEPTH),
    .ADDR_W     (ADDR_W)
) u_chk (.*);

// File: tb/sim_run_state_ctrl.sv
module sim_run_state_ctrl;

    localparam int CLK_P  = 10;
    localparam int IMEM   = 16;
    localparam int ROD    = 8;
    localparam int ROB    = 32;
    localparam int AW     = 6;
    localparam int CAP    = IMEM + ROD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [7:0]    ld_byte = '0;
    logic          ld_last = 1'b0;
    logic          ld_wr_en;
    logic [AW-1:0] ld_wr_addr;
    logic [7:0]    ld_wr_data;
    logic          op_valid = 1'b0;
    logic [7:0]    opcode = '0;
    logic [AW-1:0] pc = '0;
    logic          flt_reg = 1'b0;
    logic          flt_mem = 1'b0;
    logic [2:0]    status;
    logic          step_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    run_state_ctrl #(.IMEM_DEPTH(IMEM), .RO_DEPTH(ROD), .RO_BASE(ROB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_byte(ld_byte), .ld_last(ld_last),
        .ld_wr_en(ld_wr_en), .ld_wr_addr(ld_wr_addr), .ld_wr_data(ld_wr_data),
        .op_valid(op_valid), .opcode(opcode), .pc(pc),
        .flt_reg(flt_reg), .flt_mem(flt_mem),
        .status(status), .step_en(step_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Group widths from R5.
    function automatic int span_of(input int g);
        int w [16] = '{0, 1, 7, 4, 2, 13, 5, 2, 1, 0, 0, 0, 0, 0, 0, 0};
        return w[g];
    endfunction

    function automatic int exp_addr(input int k);
        return (k < IMEM) ? k : ROB + (k - IMEM);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ld_valid = 0; ld_last = 0; op_valid = 0;
        flt_reg = 0; flt_mem = 0; pc = '0; opcode = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Loads n bytes, last flag on the final one, checking every write.
    task automatic load_bytes(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ld_valid = 1'b1;
            ld_byte  = 8'((k * 37 + 5) & 255);
            ld_last  = (k == n - 1);
            #1;
            if (k < CAP) begin
                check({req, " wr_en"}, int'(ld_wr_en), 1);
                check({req, " addr"}, int'(ld_wr_addr), exp_addr(k));
                check({req, " data"}, int'(ld_wr_data), (k * 37 + 5) & 255);
            end else begin
                check("R3 overflow dropped", int'(ld_wr_en), 0);
            end
        end
        @(negedge clk);
        ld_valid = 1'b0; ld_last = 1'b0;
    endtask

    task automatic retire(input int op, input int p, input bit fr, input bit fm);
        @(negedge clk);
        op_valid = 1'b1; opcode = 8'(op); pc = AW'(p); flt_reg = fr; flt_mem = fm;
        @(negedge clk);
        op_valid = 1'b0; flt_reg = 0; flt_mem = 0; pc = '0;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check("R1 status in reset", int'(status), 0);
        check("R1 step_en in reset", int'(step_en), 0);
        do_reset();
        check("R1 status after reset", int'(status), 0);
        check("R1 step_en after reset", int'(step_en), 0);

        // R13: retirement during loading has no effect
        retire(8'hFF, 0, 1'b1, 1'b1);
        check("R13 op_valid ignored while loading", int'(status), 0);

        // R2, R3, R4: full capacity plus overflow bytes, last on overflow byte
        load_bytes(CAP + 3, "R2/R3 load");
        check("R4 status after last", int'(status), 2);
        check("R4 step_en after last", int'(step_en), 1);

        // R13: load stream while running writes nothing
        @(negedge clk);
        ld_valid = 1'b1; ld_last = 1'b1; #1;
        check("R13 no write when running", int'(ld_wr_en), 0);
        @(negedge clk);
        ld_valid = 1'b0; ld_last = 1'b0;
        check("R13 running unchanged", int'(status), 2);

        // R1: address restarts after reset following a partial load
        do_reset();
        load_bytes(3, "R2 short");
        do_reset();
        @(negedge clk);
        ld_valid = 1'b1; ld_byte = 8'hA5; ld_last = 1'b0; #1;
        check("R1 address restarts", int'(ld_wr_addr), 0);
        @(negedge clk);
        ld_valid = 1'b0;

        // R5..R8: exhaustive opcode sweep from a fresh running state
        for (int op = 0; op < 256; op++) begin
            int g;
            int m;
            int exp_st;
            bit ok;
            do_reset();
            load_bytes(1, "R4 single");
            g  = op / 16;
            m  = op % 16;
            ok = (m < span_of(g));
            exp_st = !ok ? 4 : (op == 128 ? 3 : 2);
            retire(op, 3, 1'b0, 1'b0);
            if (!ok)            check($sformatf("R8 R5 op=%0d", op), int'(status), exp_st);
            else if (op == 128) check("R7 halt", int'(status), exp_st);
            else                check($sformatf("R6 R5 op=%0d", op), int'(status), exp_st);
            if (op == 16 || op == 128)
                check("R7/R6 step_en", int'(step_en), op == 16 ? 1 : 0);
        end

        // R6: several valid retirements in a row stay running
        do_reset();
        load_bytes(2, "R4 two");
        for (int i = 0; i < 6; i++) begin
            retire(8'h20 + i, i, 1'b0, 1'b0);
            check("R6 sequence keeps running", int'(status), 2);
        end

        // R9, R10, R11: fault combinations and pc boundary
        for (int sel = 0; sel < 3; sel++) begin
            for (int f = 0; f < 8; f++) begin
                int op;
                int p;
                bit fr;
                bit fm;
                bit pb;
                int exp_st;
                op = (sel == 0) ? 8'h10 : (sel == 1) ? 8'h80 : 8'h5C;
                pb = f[0]; fr = f[1]; fm = f[2];
                p  = pb ? IMEM : IMEM - 1;
                do_reset();
                load_bytes(1, "R4 single");
                retire(op, p, fr, fm);
                exp_st = (pb || fr || fm) ? 4 : (op == 8'h80 ? 3 : 2);
                if (op == 8'h80 && (pb || fr || fm))
                    check("R11 failure beats halt", int'(status), exp_st);
                else if (pb)
                    check("R9 pc out of range", int'(status), exp_st);
                else if (fr || fm)
                    check("R10 exec fault", int'(status), exp_st);
                else
                    check("R9 pc at top of range ok", int'(status), exp_st);
            end
        end

        // R12: halted absorbs everything
        do_reset();
        load_bytes(1, "R4 single");
        retire(8'h80, 0, 1'b0, 1'b0);
        retire(8'hFF, 0, 1'b1, 1'b1);
        check("R12 halted after fault", int'(status), 3);
        @(negedge clk);
        ld_valid = 1'b1; ld_last = 1'b1; #1;
        check("R12 no write when halted", int'(ld_wr_en), 0);
        @(negedge clk);
        ld_valid = 1'b0; ld_last = 1'b0;
        check("R12 halted held", int'(status), 3);
        check("R12 step_en low halted", int'(step_en), 0);

        // R12: failed absorbs everything
        do_reset();
        load_bytes(1, "R4 single");
        retire(8'h00, 0, 1'b0, 1'b0);
        retire(8'h80, 0, 1'b0, 1'b0);
        retire(8'h10, 0, 1'b0, 1'b0);
        check("R12 failed held", int'(status), 4);
        @(negedge clk);
        ld_valid = 1'b1; ld_last = 1'b1; #1;
        check("R12 no write when failed", int'(ld_wr_en), 0);
        @(negedge clk);
        ld_valid = 1'b0; ld_last = 1'b0;
        check("R12 failed still", int'(status), 4);
        check("R12 step_en low failed", int'(step_en), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule